// File: doc/BRIEF.md
# Mailbox Command Issuer

This block is a bus-master state machine that carries one command through a register mailbox shared with device-side firmware and returns the outcome. A client presents a function number, a version, three 32-bit arguments and a command code, then pulses `start`. The block takes a hardware semaphore by reading a lock register until that read returns exactly 1. It then writes a signature word, the three arguments and the command word. It polls the mailbox command register until the firmware posts a response, and it releases the semaphore by reading an unlock register. Last, it reports a 32-bit result with a one-cycle `done` pulse.

All register traffic runs over a simple read/write bus with at most one transaction in flight. A request is held until `bus_req_ready` accepts it, and each transaction, read or write, completes with one `bus_rsp_valid` beat. Mailbox data on the bus is little-endian; the host side uses the opposite byte order, so every word is byte-reversed in both directions. The pause between lock retries and before each poll comes from a wait timer of `WAIT_CYCLES` clocks. The number of lock attempts and the number of polls are each capped by a parameter.

States: IDLE, LOCK_RD (lock read), LOCK_WAIT (retry pause), WR_SIGN, WR_ARG1, WR_ARG2, WR_ARG3, WR_CMD (mailbox writes), POLL_WAIT (pause before a poll), POLL_RD (poll read), FAIL_RD (error-code read), UNLOCK_RD (semaphore release) and DONE. The transitions are as follows. IDLE goes to LOCK_RD on start. LOCK_RD goes to WR_SIGN on a grant, to LOCK_WAIT on a refusal, and to DONE when the attempts are used up. LOCK_WAIT returns to LOCK_RD when the timer expires. The write states advance one per acknowledged write, and WR_CMD goes to POLL_WAIT. POLL_WAIT goes to POLL_RD, or to UNLOCK_RD when the polls are used up. POLL_RD goes back to POLL_WAIT while the command flag is still set, to FAIL_RD on a fail response, and to UNLOCK_RD otherwise. FAIL_RD goes to UNLOCK_RD, UNLOCK_RD goes to DONE, and DONE goes to IDLE.

Top module: `mbox_cmd_issuer`

## Requirements
- R1: The semaphore is requested by reading the lock register. Only a host-order value of exactly 1 grants it. Any other value (for example 0, 3 or 0x101) causes a pause of at least `WAIT_CYCLES` clocks, then another lock read.
- R2: If `LOCK_TRIES` lock reads in a row are refused, the block finishes with result 0xFFFF0001. It writes no mailbox register and issues no unlock read.
- R3: Once the lock is held, the block writes in this fixed order: the signature register, argument 1, argument 2, argument 3 and the command register. The signature host value is {16'h0000, version[7:0], function[7:0]}.
- R4: The command word is 0x80000000 OR the command code. A polled value whose bit 31 is set is not a response; the block pauses and polls again.
- R5: Each poll read comes at least `WAIT_CYCLES` clocks after the previous mailbox response. After `POLL_TRIES` polls with no response, the next pause ends in result 0xFFFF0002.
- R6: A response of 2 (fail) makes the block read argument register 1 and return that value as the result. A response of 3 returns 0xFFFF0002. Any other response with bit 31 clear, including 1, returns 0.
- R7: Every run that obtained the lock ends with one read of the unlock register, issued after all other mailbox traffic and before `done`. No transaction follows it.
- R8: Write data on the bus is the byte-reversed host value, and read data is byte-reversed back into host order.
- R9: `busy` rises the cycle after an accepted `start` and stays high until `done`. `done` is a one-cycle pulse, and `result` is valid while `done` is high. When idle, no bus request is made.
- R10: A `start` pulse while `busy` is high has no effect. The run in progress keeps its latched operands, and no second run follows.
- R11: At most one bus transaction is outstanding. An unaccepted request keeps its address, direction and data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| func_num | input | 8 | Function number placed in the signature low byte |
| version | input | 8 | Version placed in the signature second byte |
| arg1 | input | 32 | First argument, host order |
| arg2 | input | 32 | Second argument, host order |
| arg3 | input | 32 | Third argument, host order |
| cmd_code | input | 32 | Command code; bit 31 is forced set on the bus |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | 0 success, 0xFFFF0001 lock timeout, 0xFFFF0002 response timeout, else firmware error code |
| bus_req_valid | output | 1 | Register request valid |
| bus_req_ready | input | 1 | Register request accepted |
| bus_req_write | output | 1 | 1 write, 0 read |
| bus_req_addr | output | AW | Register address |
| bus_req_wdata | output | 32 | Write data, little-endian |
| bus_rsp_valid | input | 1 | Transaction completion beat |
| bus_rsp_rdata | input | 32 | Read data, little-endian |

## Verification
The bench goes after lock values that are near 1 but not 1, such as 0x101 or 3. A design that tests only the low bit would write the mailbox without holding the semaphore. It also tests a grant on the very last permitted attempt and a response on the very last permitted poll, where an off-by-one in either counter would report a timeout that should not happen. The fail path must read argument 1 and still release the lock, and a firmware timeout code must not be taken as success. A design that skipped the byte reversal, shortened the retry pause or reacted to a second `start` would put a mismatching transaction on the bus or bring a retry read in too early.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOCK_RD,
        ST_LOCK_WAIT,
        ST_WR_SIGN,
        ST_WR_ARG1,
        ST_WR_ARG2,
        ST_WR_ARG3,
        ST_WR_CMD,
        ST_POLL_WAIT,
        ST_POLL_RD,
        ST_FAIL_RD,
        ST_UNLOCK_RD,
        ST_DONE
    } mbox_state_e;

    localparam logic [31:0] RES_OK           = 32'h0000_0000;
    localparam logic [31:0] RES_LOCK_TIMEOUT = 32'hFFFF_0001;
    localparam logic [31:0] RES_RSP_TIMEOUT  = 32'hFFFF_0002;

    localparam logic [31:0] CMD_FLAG     = 32'h8000_0000;
    localparam logic [31:0] LOCK_GRANTED = 32'h0000_0001;
    localparam logic [31:0] RSP_FAIL     = 32'h0000_0002;
    localparam logic [31:0] RSP_TIMEOUT  = 32'h0000_0003;

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
    parameter int WAIT_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int TW = $clog2(WAIT_CYCLES + 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= TW'(WAIT_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire = run_q && (cnt_q == '0);

endmodule

// File: rtl/mbox_try_counter.sv
module mbox_try_counter #(
    parameter int LIMIT = 4000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        inc,
    output logic [$clog2(LIMIT+1)-1:0]  count
);
    localparam int CW = $clog2(LIMIT + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CW'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/mbox_bus_port.sv
module mbox_bus_port
    import mbox_pkg::*;
#(
    parameter int AW        = 16,
    parameter bit HOST_SWAP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_go,
    input  logic          op_write,
    input  logic [AW-1:0] op_addr,
    input  logic [31:0]   op_wdata,
    output logic          op_done,
    output logic [31:0]   op_rdata,
    output logic          bus_req_valid,
    input  logic          bus_req_ready,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_addr,
    output logic [31:0]   bus_req_wdata,
    input  logic          bus_rsp_valid,
    input  logic [31:0]   bus_rsp_rdata
);
    logic [31:0] line_wdata;
    logic        waiting_q;

    generate
        if (HOST_SWAP) begin : g_swap
            assign line_wdata = swap32(op_wdata);
            assign op_rdata   = swap32(bus_rsp_rdata);
        end else begin : g_pass
            assign line_wdata = op_wdata;
            assign op_rdata   = bus_rsp_rdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req_valid <= 1'b0;
            bus_req_write <= 1'b0;
            bus_req_addr  <= '0;
            bus_req_wdata <= '0;
            waiting_q     <= 1'b0;
        end else if (bus_req_valid) begin
            if (bus_req_ready) begin
                bus_req_valid <= 1'b0;
                waiting_q     <= 1'b1;
            end
        end else if (waiting_q) begin
            if (bus_rsp_valid) begin
                waiting_q <= 1'b0;
            end
        end else if (op_go) begin
            bus_req_valid <= 1'b1;
            bus_req_write <= op_write;
            bus_req_addr  <= op_addr;
            bus_req_wdata <= line_wdata;
        end
    end

    assign op_done = waiting_q && bus_rsp_valid;

endmodule

// File: rtl/mbox_cmd_issuer.sv
module mbox_cmd_issuer
    import mbox_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            WAIT_CYCLES = 125000,
    parameter int            LOCK_TRIES  = 4000,
    parameter int            POLL_TRIES  = 4000,
    parameter bit            HOST_SWAP   = 1'b1,
    parameter logic [AW-1:0] ADDR_LOCK   = 16'h0040,
    parameter logic [AW-1:0] ADDR_UNLOCK = 16'h0044,
    parameter logic [AW-1:0] ADDR_SIGN   = 16'h0100,
    parameter logic [AW-1:0] ADDR_ARG1   = 16'h0104,
    parameter logic [AW-1:0] ADDR_ARG2   = 16'h0108,
    parameter logic [AW-1:0] ADDR_ARG3   = 16'h010C,
    parameter logic [AW-1:0] ADDR_CMD    = 16'h0110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    func_num,
    input  logic [7:0]    version,
    input  logic [31:0]   arg1,
    input  logic [31:0]   arg2,
    input  logic [31:0]   arg3,
    input  logic [31:0]   cmd_code,
    output logic          busy,
    output logic          done,
    output logic [31:0]   result,
    output logic          bus_req_valid,
    input  logic          bus_req_ready,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_addr,
    output logic [31:0]   bus_req_wdata,
    input  logic          bus_rsp_valid,
    input  logic [31:0]   bus_rsp_rdata
);
    localparam int LCW = $clog2(LOCK_TRIES + 1);
    localparam int PCW = $clog2(POLL_TRIES + 1);
    localparam logic [LCW-1:0] LOCK_LAST = LCW'(LOCK_TRIES - 1);
    localparam logic [PCW-1:0] POLL_ALL  = PCW'(POLL_TRIES);

    mbox_state_e st_q, st_d;
    logic [31:0] res_q, res_d;
    logic [31:0] sign_q, a1_q, a2_q, a3_q, cmdw_q;
    logic        issued_q;

    logic          op_go, op_write, op_done;
    logic [AW-1:0] op_addr;
    logic [31:0]   op_wdata, op_rdata;
    logic          bus_state;

    logic           tmr_start, tmr_expire;
    logic           lock_clr, lock_inc, poll_clr, poll_inc;
    logic [LCW-1:0] lock_cnt;
    logic [PCW-1:0] poll_cnt;

    mbox_bus_port #(
        .AW       (AW),
        .HOST_SWAP(HOST_SWAP)
    ) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_go        (op_go),
        .op_write     (op_write),
        .op_addr      (op_addr),
        .op_wdata     (op_wdata),
        .op_done      (op_done),
        .op_rdata     (op_rdata),
        .bus_req_valid(bus_req_valid),
        .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write),
        .bus_req_addr (bus_req_addr),
        .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    mbox_wait_timer #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .expire(tmr_expire)
    );

    mbox_try_counter #(
        .LIMIT(LOCK_TRIES)
    ) u_lock_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lock_clr),
        .inc  (lock_inc),
        .count(lock_cnt)
    );

    mbox_try_counter #(
        .LIMIT(POLL_TRIES)
    ) u_poll_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (poll_clr),
        .inc  (poll_inc),
        .count(poll_cnt)
    );

    // State register, latched operands and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            res_q    <= RES_OK;
            sign_q   <= '0;
            a1_q     <= '0;
            a2_q     <= '0;
            a3_q     <= '0;
            cmdw_q   <= '0;
            issued_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
            if (st_q == ST_IDLE && start) begin
                sign_q <= {16'h0000, version, func_num};
                a1_q   <= arg1;
                a2_q   <= arg2;
                a3_q   <= arg3;
                cmdw_q <= cmd_code | CMD_FLAG;
            end
            if (op_done) begin
                issued_q <= 1'b0;
            end else if (op_go) begin
                issued_q <= 1'b1;
            end
        end
    end

    // Next state, counter and timer control
    always_comb begin
        st_d      = st_q;
        res_d     = res_q;
        lock_clr  = 1'b0;
        lock_inc  = 1'b0;
        poll_clr  = 1'b0;
        poll_inc  = 1'b0;
        tmr_start = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d     = ST_LOCK_RD;
                    res_d    = RES_OK;
                    lock_clr = 1'b1;
                    poll_clr = 1'b1;
                end
            end
            ST_LOCK_RD: begin
                if (op_done) begin
                    lock_inc = 1'b1;
                    if (op_rdata == LOCK_GRANTED) begin
                        st_d = ST_WR_SIGN;
                    end else if (lock_cnt == LOCK_LAST) begin
                        res_d = RES_LOCK_TIMEOUT;
                        st_d  = ST_DONE;
                    end else begin
                        st_d      = ST_LOCK_WAIT;
                        tmr_start = 1'b1;
                    end
                end
            end
            ST_LOCK_WAIT: begin
                if (tmr_expire) begin
                    st_d = ST_LOCK_RD;
                end
            end
            ST_WR_SIGN: if (op_done) st_d = ST_WR_ARG1;
            ST_WR_ARG1: if (op_done) st_d = ST_WR_ARG2;
            ST_WR_ARG2: if (op_done) st_d = ST_WR_ARG3;
            ST_WR_ARG3: if (op_done) st_d = ST_WR_CMD;
            ST_WR_CMD: begin
                if (op_done) begin
                    st_d      = ST_POLL_WAIT;
                    tmr_start = 1'b1;
                end
            end
            ST_POLL_WAIT: begin
                if (tmr_expire) begin
                    if (poll_cnt == POLL_ALL) begin
                        res_d = RES_RSP_TIMEOUT;
                        st_d  = ST_UNLOCK_RD;
                    end else begin
                        poll_inc = 1'b1;
                        st_d     = ST_POLL_RD;
                    end
                end
            end
            ST_POLL_RD: begin
                if (op_done) begin
                    if (op_rdata[31]) begin
                        st_d      = ST_POLL_WAIT;
                        tmr_start = 1'b1;
                    end else if (op_rdata == RSP_FAIL) begin
                        st_d = ST_FAIL_RD;
                    end else if (op_rdata == RSP_TIMEOUT) begin
                        res_d = RES_RSP_TIMEOUT;
                        st_d  = ST_UNLOCK_RD;
                    end else begin
                        res_d = RES_OK;
                        st_d  = ST_UNLOCK_RD;
                    end
                end
            end
            ST_FAIL_RD: begin
                if (op_done) begin
                    res_d = op_rdata;
                    st_d  = ST_UNLOCK_RD;
                end
            end
            ST_UNLOCK_RD: if (op_done) st_d = ST_DONE;
            ST_DONE:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Outputs and bus operation selection
    always_comb begin
        op_write  = 1'b0;
        op_addr   = ADDR_LOCK;
        op_wdata  = '0;
        bus_state = 1'b1;
        unique case (st_q)
            ST_LOCK_RD:   op_addr = ADDR_LOCK;
            ST_WR_SIGN:   begin op_write = 1'b1; op_addr = ADDR_SIGN; op_wdata = sign_q; end
            ST_WR_ARG1:   begin op_write = 1'b1; op_addr = ADDR_ARG1; op_wdata = a1_q;   end
            ST_WR_ARG2:   begin op_write = 1'b1; op_addr = ADDR_ARG2; op_wdata = a2_q;   end
            ST_WR_ARG3:   begin op_write = 1'b1; op_addr = ADDR_ARG3; op_wdata = a3_q;   end
            ST_WR_CMD:    begin op_write = 1'b1; op_addr = ADDR_CMD;  op_wdata = cmdw_q; end
            ST_POLL_RD:   op_addr = ADDR_CMD;
            ST_FAIL_RD:   op_addr = ADDR_ARG1;
            ST_UNLOCK_RD: op_addr = ADDR_UNLOCK;
            default:      bus_state = 1'b0;
        endcase
        op_go  = bus_state && !issued_q;
        busy   = (st_q != ST_IDLE);
        done   = (st_q == ST_DONE);
        result = res_q;
    end

endmodule

// File: rtl/mbox_cmd_issuer_chk.sv
module mbox_cmd_issuer_chk
    import mbox_pkg::*;
#(
    parameter int            AW        = 16,
    parameter bit            HOST_SWAP = 1'b1,
    parameter logic [AW-1:0] ADDR_CMD  = 16'h0110
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          bus_req_valid,
    input logic          bus_req_ready,
    input logic          bus_req_write,
    input logic [AW-1:0] bus_req_addr,
    input logic [31:0]   bus_req_wdata,
    input logic          bus_rsp_valid
);
    logic        outstanding_q;
    logic [31:0] host_w;

    generate
        if (HOST_SWAP) begin : g_swap
            assign host_w = swap32(bus_req_wdata);
        end else begin : g_pass
            assign host_w = bus_req_wdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
        end else if (bus_req_valid && bus_req_ready) begin
            outstanding_q <= 1'b1;
        end else if (bus_rsp_valid) begin
            outstanding_q <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
            && $stable(bus_req_write) && $stable(bus_req_wdata)); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !bus_req_valid); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req_valid); // R9
    AST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_write && (bus_req_addr == ADDR_CMD) |-> host_w[31]); // R4
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_rsp_valid)); // R7

endmodule

bind mbox_cmd_issuer mbox_cmd_issuer_chk #(
    .AW       (AW),
    .HOST_SWAP(HOST_SWAP),
    .ADDR_CMD (ADDR_CMD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write),
    .bus_req_addr (bus_req_addr),
    .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid)
);

// File: tb/mbox_cmd_issuer_test.sv
module mbox_cmd_issuer_test;
    localparam int W  = 3;
    localparam int LT = 5;
    localparam int PT = 4;
    localparam logic [15:0] A_LOCK = 16'h0040, A_UNLOCK = 16'h0044, A_SIGN = 16'h0100;
    localparam logic [15:0] A_ARG1 = 16'h0104, A_ARG2 = 16'h0108, A_ARG3 = 16'h010C;
    localparam logic [15:0] A_CMD  = 16'h0110;
    localparam logic [31:0] LOCK_TMO = 32'hFFFF_0001, RSP_TMO = 32'hFFFF_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  func_num = '0, version = '0;
    logic [31:0] arg1 = '0, arg2 = '0, arg3 = '0, cmd_code = '0;
    logic        busy, done;
    logic [31:0] result;
    logic        bus_req_valid, bus_req_write;
    logic        bus_req_ready = 1'b0;
    logic [15:0] bus_req_addr;
    logic [31:0] bus_req_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    int vectors = 0;
    int miscompares = 0;

    bit          exp_wr[$];
    logic [15:0] exp_ad[$];
    logic [31:0] exp_da[$];

    int          cfg_lf = 0, cfg_busy = 0;
    logic [31:0] cfg_rsp = 0, cfg_fail = 0, cfg_cmdw = 0;
    int          lock_seen = 0, poll_seen = 0;
    int          cyc = 0, last_rsp_cyc = 0, acc_n = 0, rsp_delay = 0;
    logic [31:0] rsp_hold = 0;
    bit          run_active = 0;

    always #4 clk = ~clk;

    mbox_cmd_issuer #(
        .AW(16), .WAIT_CYCLES(W), .LOCK_TRIES(LT), .POLL_TRIES(PT), .HOST_SWAP(1'b1),
        .ADDR_LOCK(A_LOCK), .ADDR_UNLOCK(A_UNLOCK), .ADDR_SIGN(A_SIGN),
        .ADDR_ARG1(A_ARG1), .ADDR_ARG2(A_ARG2), .ADDR_ARG3(A_ARG3), .ADDR_CMD(A_CMD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .func_num(func_num), .version(version),
        .arg1(arg1), .arg2(arg2), .arg3(arg3), .cmd_code(cmd_code),
        .busy(busy), .done(done), .result(result),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    function automatic logic [31:0] le(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic string tag_of(input logic [15:0] a, input bit w);
        if (a == A_LOCK) return "R1";
        if (a == A_UNLOCK) return "R7";
        if (a == A_CMD) return w ? "R4 R8" : "R5";
        if (a == A_ARG1 && !w) return "R6";
        return "R3 R8";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input bit w, input logic [15:0] a, input logic [31:0] d);
        exp_wr.push_back(w);
        exp_ad.push_back(a);
        exp_da.push_back(d);
    endtask

    // Bus responder: firmware and semaphore model
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            bus_rsp_valid <= 1'b0;
            if (rsp_delay > 0) begin
                rsp_delay--;
                if (rsp_delay == 0) begin
                    bus_rsp_valid <= 1'b1;
                    bus_rsp_rdata <= rsp_hold;
                    last_rsp_cyc = cyc;
                end
            end
            if (rst_n && bus_req_valid && bus_req_ready) begin
                logic [31:0] hv;
                hv = 32'h0;
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R7 unexpected transaction", {15'b0, bus_req_write, bus_req_addr}, 32'h0);
                end else begin
                    bit          ew;
                    logic [15:0] ea;
                    logic [31:0] ed;
                    ew = exp_wr.pop_front();
                    ea = exp_ad.pop_front();
                    ed = exp_da.pop_front();
                    chk(bus_req_write == ew && bus_req_addr == ea, tag_of(ea, ew),
                        {15'b0, bus_req_write, bus_req_addr}, {15'b0, ew, ea});
                    if (ew) chk(bus_req_wdata == ed, tag_of(ea, ew), bus_req_wdata, ed);
                end
                if (!bus_req_write) begin
                    if (bus_req_addr == A_LOCK) begin
                        if (lock_seen < cfg_lf) begin
                            case (lock_seen % 3)
                                0: hv = 32'h0000_0000;
                                1: hv = 32'h0000_0003;
                                default: hv = 32'h0000_0101;
                            endcase
                        end else begin
                            hv = 32'h1;
                        end
                        if (lock_seen > 0)
                            chk((cyc - last_rsp_cyc) >= W + 3, "R1 retry pause",
                                cyc - last_rsp_cyc, W + 3);
                        lock_seen++;
                    end else if (bus_req_addr == A_CMD) begin
                        hv = (poll_seen < cfg_busy) ? cfg_cmdw : cfg_rsp;
                        chk((cyc - last_rsp_cyc) >= W + 3, "R5 poll pause",
                            cyc - last_rsp_cyc, W + 3);
                        poll_seen++;
                    end else if (bus_req_addr == A_ARG1) begin
                        hv = cfg_fail;
                    end else if (bus_req_addr == A_UNLOCK) begin
                        hv = 32'h0;
                    end else begin
                        hv = 32'hBAD0_BAD0;
                    end
                end
                rsp_hold  = le(hv);
                acc_n++;
                rsp_delay = 1 + (acc_n % 2);
            end
            bus_req_ready <= ((cyc % 3) != 2);
        end
    end

    // Per-clock comparison of protocol and done behaviour
    initial begin
        bit prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(!((rsp_delay > 0) && bus_req_valid), "R11 single outstanding", {31'b0, bus_req_valid}, 32'h0);
                chk(!(done && (prev_done || !run_active)), "R9 done pulse", {31'b0, done}, 32'h0);
                prev_done = done;
            end
        end
    end

    task automatic run_cmd(input string tag, input logic [7:0] fn, input logic [7:0] ver,
                           input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] a3,
                           input logic [31:0] code, input int lf, input int bz,
                           input logic [31:0] rc, input logic [31:0] fc, input bit extra);
        logic [31:0] exp_res;
        int          guard;
        int          nlock;
        int          npoll;
        exp_wr.delete(); exp_ad.delete(); exp_da.delete();
        nlock = (lf >= LT) ? LT : lf + 1;
        for (int i = 0; i < nlock; i++) push(1'b0, A_LOCK, 32'h0);
        if (lf >= LT) begin
            exp_res = LOCK_TMO;
        end else begin
            push(1'b1, A_SIGN, le({16'h0, ver, fn}));
            push(1'b1, A_ARG1, le(a1));
            push(1'b1, A_ARG2, le(a2));
            push(1'b1, A_ARG3, le(a3));
            push(1'b1, A_CMD,  le(code | 32'h8000_0000));
            npoll = (bz >= PT) ? PT : bz + 1;
            for (int i = 0; i < npoll; i++) push(1'b0, A_CMD, 32'h0);
            if (bz >= PT) exp_res = RSP_TMO;
            else if (rc == 32'd2) begin
                push(1'b0, A_ARG1, 32'h0);
                exp_res = fc;
            end else if (rc == 32'd3) exp_res = RSP_TMO;
            else exp_res = 32'h0;
            push(1'b0, A_UNLOCK, 32'h0);
        end
        cfg_lf = lf; cfg_busy = bz; cfg_rsp = rc; cfg_fail = fc;
        cfg_cmdw = code | 32'h8000_0000;
        lock_seen = 0; poll_seen = 0;

        @(negedge clk);
        func_num = fn; version = ver; arg1 = a1; arg2 = a2; arg3 = a3; cmd_code = code;
        start = 1'b1; run_active = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", {31'b0, busy}, 32'h1);
        if (extra) begin
            repeat (6) @(negedge clk);
            func_num = ~fn; version = ~ver; arg1 = ~a1; arg2 = ~a2; arg3 = ~a3; cmd_code = 32'h3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, {tag, " done seen"}, {31'b0, done}, 32'h1);
        chk(result == exp_res, tag, result, exp_res);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 idle after done", {30'b0, done, busy}, 32'h0);
        repeat (12) @(negedge clk);
        chk(exp_wr.size() == 0, "R7 all transactions issued", exp_wr.size(), 32'h0);
        run_active = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && bus_req_valid == 1'b0, "R9 reset state",
            {29'b0, busy, done, bus_req_valid}, 32'h0);
        // basic success
        run_cmd("R6 ok response", 8'h02, 8'h01, 32'h1122_3344, 32'hA5A5_0001, 32'h0000_0040,
                32'h12, 0, 0, 32'd1, 32'h0, 1'b0);
        // refused lock values 0, 3, 0x101 then grant; busy polls
        run_cmd("R1 lock retry", 8'h07, 8'h3C, 32'hDEAD_BEEF, 32'h0, 32'hFFFF_FFFF,
                32'h07, 3, 2, 32'd1, 32'h0, 1'b0);
        // fail response with error code readback
        run_cmd("R6 fail code", 8'h01, 8'h01, 32'h5, 32'h6, 32'h7,
                32'h09, 0, 1, 32'd2, 32'hDEAD_0042, 1'b0);
        // firmware timeout response
        run_cmd("R6 firmware timeout", 8'h03, 8'h02, 32'h1, 32'h2, 32'h3,
                32'h0A, 1, 0, 32'd3, 32'h0, 1'b0);
        // lock never granted
        run_cmd("R2 lock timeout", 8'h01, 8'h01, 32'h1, 32'h2, 32'h3,
                32'h01, LT, 0, 32'd1, 32'h0, 1'b0);
        // no response within the poll budget
        run_cmd("R5 poll timeout", 8'h04, 8'h01, 32'h8, 32'h9, 32'hA,
                32'h0E, 0, PT, 32'd1, 32'h0, 1'b0);
        // grant on last attempt, response on last poll
        run_cmd("R5 last poll R1 last lock", 8'hF0, 8'h0F, 32'h0102_0304, 32'h0, 32'h1,
                32'h10, LT - 1, PT - 1, 32'd1, 32'h0, 1'b0);
        // other response code counts as success
        run_cmd("R6 other code", 8'h00, 8'h00, 32'h0, 32'h0, 32'h0,
                32'h05, 0, 0, 32'd5, 32'h0, 1'b0);
        // start pulse while busy is ignored
        run_cmd("R10 start while busy", 8'h05, 8'h09, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003,
                32'h0F, 1, 1, 32'd1, 32'h0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule